// File: doc/BRIEF.md
# Shared Mailbox Slot Register Bank

This block is a register bank through which two processor cores exchange short fixed-size messages. It holds 32 independent mailbox slots on one simple register bus. Each slot has a control word and a message buffer of eight 32-bit words. The control word carries a one-hot lifecycle state and an acknowledge-mode bit.

A sending core claims a slot by writing the transmit state into its control word and then fills the message words. The receiving core reads the message words. It then returns the slot to the idle state, and a polling sender watches for that idle state as its sign that the transfer has finished. If the slot is set for interrupt-style acknowledgement, that return to idle from the receive state produces a one-cycle acknowledge event for the slot. A separate block outside this one gathers those events into interrupts.

The bus is single-ported. In each cycle there is at most one access, either a read or a write. Read data is registered, and it stays on the bus until the next read.

Top module: `mbox_bank`

## Requirements
- R1: After reset, every slot's control word reads 0x0000_0010 (state IDLE, acknowledge bit 0), every message word reads 0, `busRdata` is 0 and `ackEvt` is all zero.
- R2: Slot s occupies byte addresses 0x40·s to 0x40·s+0x3F. The control word is at slot offset 0x0 and message word i (0 to 7) is at offset 0x4+4·i. Address bits [1:0] are ignored.
- R3: The control word has the state in bits [7:4], one-hot, with IDLE=0x1, TX=0x2, RX=0x4 and ACK=0x8. Bit 0 is the acknowledge mode: 1 means automatic, 0 means by interrupt. All other bits read 0 whatever was written, and a read shows exactly the state and mode last stored.
- R4: A control-word write whose bits [7:4] are not exactly one-hot leaves the slot's state unchanged, but still stores bit 0.
- R5: A read returns its data on `busRdata` after the clock edge that samples it. `busRdata` keeps that value until the next read is sampled.
- R6: Reads of slot offsets 0x24 to 0x3C return 0. Writes to those offsets change no stored word.
- R7: A control-word write that stores IDLE into a slot whose state is RX and whose acknowledge bit (before the write) is 0 raises `ackEvt[s]` for exactly the cycle after the write. With the acknowledge bit 1, or from any other state, no event is raised.
- R8: A write to one slot leaves every other slot's control word and message words unchanged.
- R9: Message words store all 32 bits. Control-word writes and message-word writes do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | An access is made this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 11 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| ackEvt | output | 32 | Per-slot one-cycle acknowledge event |

## Verification
Directed sequences come first. They walk every slot's control word after reset, write distinct patterns to the first, a middle and the last slot, and read them back through unaligned addresses. This separates slot-stride and word-stride decode errors from storage errors. Control-word writes go through each state, through reserved-bit patterns and through non-one-hot state values. IDLE writes are made from RX, from TX and under both acknowledge modes, so that missing, spurious and mis-timed acknowledge events can be told apart. A long random mix of reads and writes over all offsets, including the unmapped ones, is then compared every cycle against a behavioural model. That run exposes cross-slot aliasing and writes that leak from unmapped offsets.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_SLOTS     = 32;
  localparam int unsigned MBOX_MSG_WORDS = 8;
  localparam int unsigned MBOX_DATA_W    = 32;
  localparam int unsigned MBOX_STRIDE_B  = 64;

  localparam int unsigned MBOX_SLOT_W = $clog2(MBOX_SLOTS);
  localparam int unsigned MBOX_WORD_W = $clog2(MBOX_STRIDE_B / 4);
  localparam int unsigned MBOX_PAY_W  = $clog2(MBOX_MSG_WORDS);
  localparam int unsigned MBOX_ADDR_W = MBOX_SLOT_W + MBOX_WORD_W + 2;
  localparam int unsigned MBOX_ST_LSB = 4;
  localparam int unsigned MBOX_ST_W   = 4;

  typedef enum logic [MBOX_ST_W-1:0] {
    ST_IDLE = 4'h1,
    ST_TX   = 4'h2,
    ST_RX   = 4'h4,
    ST_ACK  = 4'h8
  } mbox_state_e;

  // strobes from decode to storage
  typedef struct packed {
    logic                   modeWr;
    logic                   payWr;
    logic                   modeRd;
    logic                   payRd;
    logic                   zeroRd;
    logic [MBOX_SLOT_W-1:0] slot;
    logic [MBOX_PAY_W-1:0]  payIdx;
  } mbox_strb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [MBOX_ADDR_W-1:0] busAddr,
  output mbox_strb_t             strb
);
  logic [MBOX_WORD_W-1:0] word;
  logic [MBOX_WORD_W-1:0] wordM1;
  logic                   isMode;
  logic                   isPay;
  logic                   unusedLow;

  assign unusedLow = ^busAddr[1:0];
  assign word      = busAddr[2 +: MBOX_WORD_W];
  assign wordM1    = word - MBOX_WORD_W'(1);
  assign isMode    = (word == '0);
  assign isPay     = !isMode && (int'(word) <= int'(MBOX_MSG_WORDS));

  always_comb begin
    strb        = '0;
    strb.slot   = busAddr[2+MBOX_WORD_W +: MBOX_SLOT_W];
    strb.payIdx = wordM1[MBOX_PAY_W-1:0];
    if (busSel) begin
      if (busWrite) begin
        strb.modeWr = isMode;
        strb.payWr  = isPay;
      end else begin
        strb.modeRd = isMode;
        strb.payRd  = isPay;
        strb.zeroRd = !isMode && !isPay;
      end
    end
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  mbox_strb_t                       strb,
  input  logic [MBOX_DATA_W-1:0]           wdata,
  output logic [MBOX_DATA_W-1:0]           rdata,
  output logic [MBOX_SLOTS-1:0]            ackEvt,
  output logic [MBOX_SLOTS*MBOX_ST_W-1:0]  stateFlat
);
  mbox_state_e            stateQ [MBOX_SLOTS];
  logic [MBOX_SLOTS-1:0]  ackQ;
  logic [MBOX_DATA_W-1:0] payQ [MBOX_SLOTS][MBOX_MSG_WORDS];
  logic [MBOX_DATA_W-1:0] modeWord [MBOX_SLOTS];
  logic [MBOX_ST_W-1:0]   newSt;
  logic                   newStOk;

  assign newSt   = wdata[MBOX_ST_LSB +: MBOX_ST_W];
  assign newStOk = $onehot(newSt);

  for (genvar s = 0; s < int'(MBOX_SLOTS); s++) begin : g_slot
    assign modeWord[s] = {{(MBOX_DATA_W-MBOX_ST_LSB-MBOX_ST_W){1'b0}},
                          stateQ[s], {(MBOX_ST_LSB-1){1'b0}}, ackQ[s]};
    assign stateFlat[s*MBOX_ST_W +: MBOX_ST_W] = stateQ[s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ackEvt[s] <= 1'b0;
      end else begin
        ackEvt[s] <= strb.modeWr && (strb.slot == MBOX_SLOT_W'(s)) &&
                     (stateQ[s] == ST_RX) && (newSt == ST_IDLE) && !ackQ[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < int'(MBOX_SLOTS); s++) begin
        stateQ[s] <= ST_IDLE;
      end
      ackQ <= '0;
    end else if (strb.modeWr) begin
      if (newStOk) stateQ[strb.slot] <= mbox_state_e'(newSt);
      ackQ[strb.slot] <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < int'(MBOX_SLOTS); s++) begin
        for (int w = 0; w < int'(MBOX_MSG_WORDS); w++) begin
          payQ[s][w] <= '0;
        end
      end
    end else if (strb.payWr) begin
      payQ[strb.slot][strb.payIdx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strb.modeRd) begin
      rdata <= modeWord[strb.slot];
    end else if (strb.payRd) begin
      rdata <= payQ[strb.slot][strb.payIdx];
    end else if (strb.zeroRd) begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [MBOX_ADDR_W-1:0] busAddr,
  input  logic [MBOX_DATA_W-1:0] busWdata,
  output logic [MBOX_DATA_W-1:0] busRdata,
  output logic [MBOX_SLOTS-1:0]  ackEvt
);
  mbox_strb_t                       strb;
  logic [MBOX_SLOTS*MBOX_ST_W-1:0]  stateFlat;

  mbox_ctrl u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  mbox_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .rdata     (busRdata),
    .ackEvt    (ackEvt),
    .stateFlat (stateFlat)
  );
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk
  import mbox_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             busSel,
  input logic                             busWrite,
  input logic [MBOX_ADDR_W-1:0]           busAddr,
  input logic [MBOX_DATA_W-1:0]           busRdata,
  input logic [MBOX_SLOTS-1:0]            ackEvt,
  input logic [MBOX_SLOTS*MBOX_ST_W-1:0]  stateFlat
);
  logic rdNow;
  logic [MBOX_WORD_W-1:0] word;
  assign rdNow = busSel && !busWrite;
  assign word  = busAddr[2 +: MBOX_WORD_W];

  for (genvar s = 0; s < int'(MBOX_SLOTS); s++) begin : g_st
    a_r3_state_onehot: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(stateFlat[s*MBOX_ST_W +: MBOX_ST_W]));
  end

  a_r7_single_ack: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ackEvt) <= 1);

  a_r7_ack_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (ackEvt != '0) |-> $past(busSel && busWrite && (word == '0)));

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdNow && (int'(word) > int'(MBOX_MSG_WORDS))) |=> (busRdata == '0));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdNow && (word == '0)) |=> ((busRdata & 32'hFFFF_FF0E) == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdNow |=> $stable(busRdata));
endmodule

bind mbox_bank mbox_bank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .ackEvt    (ackEvt),
  .stateFlat (stateFlat)
);

// File: tb/mbox_bank_tb_top.sv
module mbox_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [10:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] ackEvt;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural model
  logic [3:0]  mState [32];
  logic        mAck [32];
  logic [31:0] mPay [32][8];
  logic [31:0] expRd = '0;
  logic [31:0] expAck = '0;

  always #5 clk = ~clk;

  mbox_bank dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .ackEvt(ackEvt)
  );

  function automatic logic [10:0] adr(int slot, int word);
    return 11'(slot * 64 + word * 4);
  endfunction

  task automatic modelStep(logic sel, logic wr, logic [10:0] a, logic [31:0] d);
    int slot = int'(a[10:6]);
    int w = int'(a[5:2]);
    expAck = '0;
    if (!sel) return;
    if (!wr) begin
      if (w == 0) expRd = {24'h0, mState[slot], 3'b000, mAck[slot]};
      else if (w <= 8) expRd = mPay[slot][w-1];
      else expRd = '0;
    end else if (w == 0) begin
      if (mState[slot] == 4'h4 && d[7:4] == 4'h1 && !mAck[slot]) expAck[slot] = 1'b1;
      if ($countones(d[7:4]) == 1) mState[slot] = d[7:4];
      mAck[slot] = d[0];
    end else if (w <= 8) begin
      mPay[slot][w-1] = d;
    end
  endtask

  task automatic check(string tag);
    compared++;
    if (busRdata !== expRd) begin
      mismatched++;
      $display("FAIL %s busRdata got %h expected %h", tag, busRdata, expRd);
    end
    compared++;
    if (ackEvt !== expAck) begin
      mismatched++;
      $display("FAIL %s ackEvt got %h expected %h", tag, ackEvt, expAck);
    end
  endtask

  task automatic step(logic sel, logic wr, logic [10:0] a, logic [31:0] d, string tag);
    busSel = sel; busWrite = wr; busAddr = a; busWdata = d;
    @(posedge clk);
    modelStep(sel, wr, a, d);
    @(negedge clk);
    busSel = 1'b0;
    check(tag);
  endtask

  task automatic rd(int slot, int w, string tag);
    step(1'b1, 1'b0, adr(slot, w), 32'h0, tag);
  endtask

  task automatic wr(int slot, int w, logic [31:0] d, string tag);
    step(1'b1, 1'b1, adr(slot, w), d, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int s = 0; s < 32; s++) begin
      mState[s] = 4'h1; mAck[s] = 1'b0;
      for (int w = 0; w < 8; w++) mPay[s][w] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset outputs");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset");

    // R1/R2: every control word after reset, some message words
    for (int s = 0; s < 32; s++) rd(s, 0, "R1 control reset");
    for (int w = 1; w <= 8; w++) rd(31, w, "R1 message reset");

    // R2/R9: distinct patterns, first/middle/last slot
    for (int w = 1; w <= 8; w++) begin
      wr(0, w, 32'hA000_0000 | 32'(w), "R9 write slot0");
      wr(17, w, 32'h5A5A_0000 ^ 32'(w * 32'h1111), "R9 write slot17");
      wr(31, w, ~32'(w), "R9 write slot31");
    end
    for (int w = 1; w <= 8; w++) begin
      rd(0, w, "R2 readback slot0");
      rd(17, w, "R2 readback slot17");
      step(1'b1, 1'b0, adr(31, w) | 11'h3, 32'h0, "R2 unaligned read");
    end
    rd(1, 1, "R8 neighbour slot untouched");
    rd(30, 8, "R8 neighbour slot untouched");

    // R3: states and reserved bits
    wr(5, 0, 32'h0000_0021, "R3 write TX auto");
    rd(5, 0, "R3 TX auto readback");
    wr(5, 0, 32'hFFFF_FF40, "R3 reserved bits written");
    rd(5, 0, "R3 reserved read zero");
    rd(5, 3, "R9 payload kept after control write");
    // R4: non-one-hot state
    wr(5, 0, 32'h0000_0031, "R4 two-hot state");
    rd(5, 0, "R4 state kept, ack stored");
    wr(5, 0, 32'h0000_0000, "R4 zero state");
    rd(5, 0, "R4 state kept, ack cleared");
    // R7: RX -> IDLE with interrupt ack
    wr(5, 0, 32'h0000_0010, "R7 ack event expected");
    step(1'b0, 1'b0, 11'h0, 32'h0, "R7 event lasts one cycle");
    rd(5, 0, "R7 polled idle");
    // R7: auto ack suppresses event
    wr(7, 0, 32'h0000_0041, "R7 RX auto");
    wr(7, 0, 32'h0000_0011, "R7 no event in auto mode");
    // R7: IDLE from TX, no event
    wr(9, 0, 32'h0000_0020, "R7 TX interrupt mode");
    wr(9, 0, 32'h0000_0010, "R7 no event from TX");
    // R7: ACK state and then IDLE from RX on last slot
    wr(31, 0, 32'h0000_0080, "R3 ACK state");
    rd(31, 0, "R3 ACK readback");
    wr(31, 0, 32'h0000_0040, "R7 RX last slot");
    wr(31, 0, 32'h0000_0010, "R7 event last slot");

    // R6: unmapped writes ignored, reads zero
    for (int w = 9; w < 16; w++) wr(0, w, 32'hDEAD_BEEF, "R6 unmapped write");
    for (int w = 0; w < 16; w++) rd(0, w, "R6 slot0 after unmapped writes");
    rd(1, 0, "R8 slot1 control untouched");

    // R8: random mix compared every cycle
    for (int i = 0; i < 4000; i++) begin
      int s = int'($urandom_range(31, 0));
      int w = int'($urandom_range(15, 0));
      logic [31:0] d = $urandom;
      int op = int'($urandom_range(3, 0));
      if (w == 0 && $urandom_range(1, 0) == 1) d[7:4] = 4'(1 << $urandom_range(3, 0));
      if (op == 0) step(1'b0, 1'b0, adr(s, w), d, "R5 idle hold");
      else step(1'b1, op[0], adr(s, w), d, "R8 random mix");
    end
    for (int s = 0; s < 32; s++) rd(s, 0, "R8 final control sweep");

    done = 1;
    summary();
  end
endmodule